// File: doc/BRIEF.md
# Framed SPI Flash Sequencer

This block is a single-lane SPI master behind a small register port. Software fills a transmit FIFO, writes a frame descriptor, and the block then runs one chip-select frame. A frame has a total byte count and a command byte count. Command bytes come from the transmit FIFO and whatever the slave returns during them is dropped. The bytes after the command go into a receive FIFO. During those data bytes the block sends filler 0xFF. When the command count is zero, every byte of the frame is full duplex: each one comes from the FIFO and each one is kept.

SCLK is the system clock divided by twice a programmable rate. The idle level of SCLK can be set for SPI mode 0 or mode 3. Latched and live status flags drive one interrupt line through an enable mask.

Each FIFO acts as a valid/ready stream with the engine on the other side. The engine pops a transmit byte only when that FIFO holds one. If it does not, SCLK stalls until software writes a byte. The engine also does not start a byte that must be stored while the receive FIFO is full. The register port itself never stalls. A write to TXDATA while the transmit FIFO is full is dropped, so software must watch the space and full flags in STATUS.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, irq is 0, and STATUS (word address 4) reads 0x18. Register word addresses: CTRL=0, FRAME=1, FRAME_UP=2, IEN=3, STATUS=4, TXDATA=5 (write pushes bits 7:0), RXDATA=6 (read pops; an empty FIFO reads 0).
- R2: A frame starts only when FRAME is written while CTRL bit 0 (enable) is 1 and the core is idle. The frame total is {FRAME_UP[15:0], FRAME[15:0]} and must be nonzero. The command count is FRAME[24:16]. A FRAME write that is disabled, busy or has a zero total is ignored.
- R3: With command count 0, every byte is taken from the transmit FIFO and every received byte is stored in the receive FIFO, in order.
- R4: With command count ≥ total, every byte is taken from the transmit FIFO and no received byte is stored.
- R5: With 0 < command count < total, the first command-count bytes come from the FIFO and their received data is dropped. The remaining bytes send 0xFF and their received bytes are stored.
- R6: Each SCLK half period lasts N system clocks, where N = CTRL[27:24] and a value of 0 acts as 1. Data goes out MSB first, SPI_MOSI changes only while SCLK is low, and MISO is sampled at the SCLK rising edge.
- R7: CTRL bit 10 sets the SCLK idle level: 1 is idle high (mode 3) and 0 is idle low (mode 0).
- R8: spi_cs_n stays low for the whole frame and rises 2N clocks after the last bit ends, which is 3N clocks after the last SCLK rising edge.
- R9: A FIFO-sourced byte slot with an empty transmit FIFO, or a stored byte slot with a full receive FIFO, holds SCLK at idle with chip select still low until the condition clears.
- R10: STATUS bit 0 is transmit done and bit 1 is frame done. Bit 2 is receive data available and is set on each store. These three are latched and each is cleared by writing 1 to it. Bit 3 is transmit space, bit 4 is receive empty, bit 5 is transmit full and bit 7 is ready; these are live.
- R11: irq is 1 exactly when STATUS AND IEN[7:0] is nonzero.
- R12: Clearing the enable bit aborts a frame. One clock later spi_cs_n is 1 and SCLK is at its idle level, and neither done flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RXDATA) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with a FIFO depth of 4 and a 32-bit counter. Frames of up to eight bytes therefore overrun both FIFOs. This reaches the transmit stall, which is forced further by holding back writes, and the receive back-pressure stall, which is forced by delaying reads. Writing a nonzero upper count with a zero low half starts a 65536-byte frame. That frame shows the upper register taking part in the total, and it is then cut short by the abort path.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LOAD, SQ_LOW, SQ_HIGH, SQ_TAIL
  } seq_state_e;

  localparam logic [2:0] ADR_CTRL     = 3'd0;
  localparam logic [2:0] ADR_FRAME    = 3'd1;
  localparam logic [2:0] ADR_FRAME_UP = 3'd2;
  localparam logic [2:0] ADR_IEN      = 3'd3;
  localparam logic [2:0] ADR_STATUS   = 3'd4;
  localparam logic [2:0] ADR_TXDATA   = 3'd5;
  localparam logic [2:0] ADR_RXDATA   = 3'd6;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_IDLE_BIT = 10;
  localparam int CTL_RATE_LSB = 24;

  localparam int ST_TXDONE = 0;
  localparam int ST_FRDONE = 1;
  localparam int ST_RXAVL  = 2;
  localparam int ST_TXSPC  = 3;
  localparam int ST_RXEMP  = 4;
  localparam int ST_TXFUL  = 5;
  localparam int ST_READY  = 7;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  // DEPTH must be a power of two, at least 2
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;

  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign dout  = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push && !full) wr_q <= wr_q + (AW+1)'(1);
      if (pop && !empty) rd_q <= rd_q + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpol,
  input  logic [3:0]       rate,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  input  logic [8:0]       cmd,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             tx_fin,
  output logic             rx_fin,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int DIV_W = 5;

  seq_state_e       st_q;
  logic [CNT_W-1:0] tot_q, idx_q;
  logic [8:0]       cmd_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tsh_q, rsh_q;
  logic             keep_q;

  logic [DIV_W-1:0] half, half_m1, full_m1;
  logic             half_end, tail_end;
  logic             cmd_phase, from_fifo, keep_now, can_go, last_bit_end, last_byte;

  assign half     = (rate == 4'd0) ? DIV_W'(1) : {1'b0, rate};
  assign half_m1  = half - DIV_W'(1);
  assign full_m1  = {half[3:0], 1'b0} - DIV_W'(1);
  assign half_end = (div_q == half_m1);
  assign tail_end = (div_q == full_m1);

  assign cmd_phase = (cmd_q != 9'd0) && ({{(CNT_W-9){1'b0}}, cmd_q} > idx_q);
  assign from_fifo = cmd_phase || (cmd_q == 9'd0);
  assign keep_now  = !cmd_phase;
  assign can_go    = !(from_fifo && tx_empty) && !(keep_now && rx_full);

  assign last_bit_end = (st_q == SQ_HIGH) && half_end && (bit_q == 3'd0);
  assign last_byte    = (idx_q == tot_q - CNT_W'(1));

  assign tx_pop  = en && (st_q == SQ_LOAD) && can_go && from_fifo;
  assign rx_push = en && last_bit_end && keep_q;
  assign rx_data = rsh_q;
  assign tx_fin  = en && last_bit_end && last_byte;
  assign rx_fin  = en && (st_q == SQ_TAIL) && tail_end;
  assign busy    = (st_q != SQ_IDLE);

  assign cs_n = (st_q == SQ_IDLE);
  assign mosi = tsh_q[7];
  always_comb begin
    case (st_q)
      SQ_LOW:  sclk = 1'b0;
      SQ_HIGH: sclk = 1'b1;
      default: sclk = cpol;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      tot_q  <= '0;
      idx_q  <= '0;
      cmd_q  <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      keep_q <= 1'b0;
    end else if (!en) begin
      st_q  <= SQ_IDLE;
      div_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start && (total != '0)) begin
            tot_q <= total;
            cmd_q <= cmd;
            idx_q <= '0;
            st_q  <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          if (can_go) begin
            tsh_q  <= from_fifo ? tx_data : FILL_BYTE;
            keep_q <= keep_now;
            bit_q  <= 3'd7;
            div_q  <= '0;
            st_q   <= SQ_LOW;
          end
        end
        SQ_LOW: begin
          if (half_end) begin
            rsh_q <= {rsh_q[6:0], miso};
            div_q <= '0;
            st_q  <= SQ_HIGH;
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        SQ_HIGH: begin
          if (half_end) begin
            div_q <= '0;
            if (bit_q == 3'd0) begin
              idx_q <= idx_q + CNT_W'(1);
              st_q  <= last_byte ? SQ_TAIL : SQ_LOAD;
            end else begin
              tsh_q <= {tsh_q[6:0], 1'b0};
              bit_q <= bit_q - 3'd1;
              st_q  <= SQ_LOW;
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        SQ_TAIL: begin
          if (tail_end) begin
            div_q <= '0;
            st_q  <= SQ_IDLE;
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int UP_W = CNT_W - 16;

  logic             en_q, cpol_q;
  logic [3:0]       rate_q;
  logic [15:0]      frame_lo_q;
  logic [8:0]       cmd_q;
  logic [UP_W-1:0]  up_q;
  logic [7:0]       ien_q;
  logic             txd_q, frd_q, rxa_q;

  logic wr_ctrl, wr_frame, wr_up, wr_ien, wr_stat, wr_tx, rd_rx;
  logic tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
  logic [7:0] tx_dout, rx_dout, rx_din;
  logic busy, tx_fin, rx_fin, start, ready;
  logic [7:0] status;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[31:28];

  assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_frame = bus_wr && (bus_addr == ADR_FRAME);
  assign wr_up    = bus_wr && (bus_addr == ADR_FRAME_UP);
  assign wr_ien   = bus_wr && (bus_addr == ADR_IEN);
  assign wr_stat  = bus_wr && (bus_addr == ADR_STATUS);
  assign wr_tx    = bus_wr && (bus_addr == ADR_TXDATA);
  assign rd_rx    = bus_rd && (bus_addr == ADR_RXDATA);

  assign ready = en_q && !busy;
  assign start = wr_frame && ready;

  spi_seq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .push(wr_tx), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty)
  );

  spi_seq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
    .pop(rd_rx), .dout(rx_dout), .full(rx_full), .empty(rx_empty)
  );

  spi_seq_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en_q), .cpol(cpol_q), .rate(rate_q),
    .start(start), .total({up_q, bus_wdata[15:0]}), .cmd(bus_wdata[24:16]),
    .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_din),
    .busy(busy), .tx_fin(tx_fin), .rx_fin(rx_fin),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      cpol_q     <= 1'b0;
      rate_q     <= 4'd0;
      frame_lo_q <= '0;
      cmd_q      <= '0;
      up_q       <= '0;
      ien_q      <= '0;
      txd_q      <= 1'b0;
      frd_q      <= 1'b0;
      rxa_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[CTL_EN_BIT];
        cpol_q <= bus_wdata[CTL_IDLE_BIT];
        rate_q <= bus_wdata[CTL_RATE_LSB +: 4];
      end
      if (start) begin
        frame_lo_q <= bus_wdata[15:0];
        cmd_q      <= bus_wdata[24:16];
      end
      if (wr_up)  up_q  <= bus_wdata[UP_W-1:0];
      if (wr_ien) ien_q <= bus_wdata[7:0];
      // set wins over a same-cycle clear
      if (tx_fin) txd_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_TXDONE]) txd_q <= 1'b0;
      if (rx_fin) frd_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_FRDONE]) frd_q <= 1'b0;
      if (rx_push) rxa_q <= 1'b1;
      else if (wr_stat && bus_wdata[ST_RXAVL]) rxa_q <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_TXDONE] = txd_q;
    status[ST_FRDONE] = frd_q;
    status[ST_RXAVL]  = rxa_q;
    status[ST_TXSPC]  = !tx_full;
    status[ST_RXEMP]  = rx_empty;
    status[ST_TXFUL]  = tx_full;
    status[ST_READY]  = ready;
  end

  assign irq = |(status & ien_q);

  always_comb begin
    case (bus_addr)
      ADR_CTRL:     bus_rdata = {4'd0, rate_q, 13'd0, cpol_q, 9'd0, en_q};
      ADR_FRAME:    bus_rdata = {7'd0, cmd_q, frame_lo_q};
      ADR_FRAME_UP: bus_rdata = {{(32-UP_W){1'b0}}, up_q};
      ADR_IEN:      bus_rdata = {24'd0, ien_q};
      ADR_STATUS:   bus_rdata = {24'd0, status};
      ADR_RXDATA:   bus_rdata = {24'd0, rx_empty ? 8'd0 : rx_dout};
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic tx_pop,
  input logic tx_empty,
  input logic rx_push,
  input logic rx_full,
  input logic rx_avail,
  input logic ready,
  input logic rx_fin
);
  // R12: a cleared enable leaves the pins idle one clock later
  a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cs_n);

  // R7: outside a frame SCLK rests at the selected idle level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cpol));

  // R6: MOSI does not move while SCLK stays high inside a frame
  a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(!cs_n) && $past(sclk)) |-> $stable(mosi));

  // R9: the engine never pops an empty transmit FIFO
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R9: the engine never stores into a full receive FIFO
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  // R10: every store raises the data-available flag
  a_r10_avail_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> rx_avail);

  // R2: chip select only falls after a cycle in which the core was ready
  a_r2_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(ready));

  // R8: chip select rises only at the end of the tail or on abort
  a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(rx_fin) || !$past(en)));
endmodule

bind spi_frame_seq spi_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .cpol(cpol_q),
  .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
  .rx_avail(rxa_q), .ready(ready), .rx_fin(rx_fin)
);

// File: tb/tb_spi_frame_seq.sv
module tb_spi_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int CNT_W      = 32;

  localparam logic [2:0] A_CTRL = 3'd0, A_FRAME = 3'd1, A_UP = 3'd2, A_IEN = 3'd3,
                         A_STAT = 3'd4, A_TX = 3'd5, A_RX = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_checks = 0;
  int n_errors = 0;

  spi_frame_seq #(.FIFO_DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---- slave model ----
  logic [7:0] resp [64];
  logic [7:0] cap  [64];
  int  rise_cnt = 0;
  time last_rise_t = 0, first_per = 0, cs_rise_t = 0;

  always @(negedge spi_cs_n) begin
    rise_cnt = 0;
    spi_miso = resp[0][7];
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n === 1'b0) begin
      cap[(rise_cnt/8)%64] = {cap[(rise_cnt/8)%64][6:0], spi_mosi};
      if (rise_cnt == 1) first_per = $time - last_rise_t;
      last_rise_t = $time;
      rise_cnt++;
      spi_miso <= resp[(rise_cnt/8)%64][7-(rise_cnt%8)];
    end
  end

  always @(posedge spi_cs_n) cs_rise_t = $time;

  // ---- helpers ----
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input int rate, input bit cpol, input bit en);
    return (32'(rate & 15) << 24) | (32'(cpol) << 10) | 32'(en);
  endfunction

  function automatic int half_of(input int rate);
    return (rate == 0) ? 1 : rate;
  endfunction

  task automatic run_frame(input int total, input int cmd, input int rate, input bit cpol,
                           input int hold, input int rx_lag, input bit rewrite,
                           input bit keep_flags);
    logic [7:0]  txb [64];
    logic [31:0] st, d;
    int n_fifo, n_keep, pushed, popped, iter, base, n;
    bit lag_checked;
    string tag;
    n_fifo = (cmd == 0 || cmd >= total) ? total : cmd;
    n_keep = (cmd == 0) ? total : ((cmd >= total) ? 0 : total - cmd);
    base   = (cmd == 0) ? 0 : cmd;
    tag    = (cmd == 0) ? "R3" : ((cmd >= total) ? "R4" : "R5");
    n      = half_of(rate);
    for (int i = 0; i < 64; i++) begin
      resp[i] = 8'($urandom);
      txb[i]  = 8'($urandom);
    end
    wr(A_CTRL, ctrl_word(rate, cpol, 1'b1));
    pushed = 0; popped = 0; lag_checked = 0;
    if (hold == 0) begin
      while (pushed < n_fifo && pushed < DEPTH) begin
        wr(A_TX, {24'd0, txb[pushed]});
        pushed++;
      end
    end
    wr(A_UP, 32'd0);
    wr(A_FRAME, 32'(total) | (32'(cmd) << 16));
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R9 chip select held low while stalled", {31'd0, spi_cs_n}, 32'd0);
      chk("R9 no SCLK edge while transmit FIFO empty", 32'(rise_cnt), 32'd0);
      chk("R9 SCLK at idle while stalled", {31'd0, spi_sclk}, {31'd0, cpol});
    end
    if (rewrite) wr(A_FRAME, 32'(total + 2) | (32'(cmd) << 16));
    iter = 0;
    while (1) begin
      rd(A_STAT, st);
      if (pushed < n_fifo && st[3]) begin
        wr(A_TX, {24'd0, txb[pushed]});
        pushed++;
      end else if (!st[4] && iter >= rx_lag) begin
        if (rx_lag > 0 && !lag_checked && n_keep > DEPTH) begin
          lag_checked = 1;
          chk("R9 receive back-pressure stall point", 32'(rise_cnt),
              32'(8 * ((total - n_keep) + DEPTH)));
        end
        rd(A_RX, d);
        chk({tag, " stored byte"}, d, {24'd0, resp[base + popped]});
        popped++;
      end else if (st[7] && popped == n_keep && pushed == n_fifo) begin
        break;
      end
      iter++;
      if (iter > 6000) begin
        chk({tag, " frame completion"}, 32'(popped), 32'(n_keep));
        break;
      end
    end
    repeat (3) @(negedge clk);
    chk("R2 rising edges equal 8 x total (busy rewrite ignored)", 32'(rise_cnt), 32'(8*total));
    for (int i = 0; i < total; i++) begin
      chk({tag, " transmitted byte"}, {24'd0, cap[i]},
          {24'd0, (cmd != 0 && cmd < total && i >= cmd) ? 8'hFF : txb[i]});
    end
    chk("R6 SCLK period is 2N clocks", 32'(first_per), 32'(2*n*CLK_PERIOD));
    chk("R8 chip select rises 3N after last rise", 32'(cs_rise_t - last_rise_t),
        32'(3*n*CLK_PERIOD));
    chk("R7 SCLK idle level after frame", {31'd0, spi_sclk}, {31'd0, cpol});
    rd(A_STAT, st);
    chk("R10 both done flags latched", {30'd0, st[1:0]}, 32'd3);
    chk("R10 receive FIFO empty flag", {31'd0, st[4]}, 32'd1);
    if (!keep_flags) wr(A_STAT, 32'h7);
  endtask

  // ---- watchdog ----
  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  // ---- main ----
  initial begin
    logic [31:0] st, d;
    void'($urandom(32'd5151));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 chip select high after reset", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 SCLK low after reset", {31'd0, spi_sclk}, 32'd0);
    chk("R1 irq low after reset", {31'd0, irq}, 32'd0);
    rd(A_STAT, st);
    chk("R1 STATUS after reset", st, 32'h18);

    // R2 disabled FRAME write ignored
    wr(A_FRAME, 32'd3);
    repeat (5) @(negedge clk);
    chk("R2 disabled frame write ignored", {31'd0, spi_cs_n}, 32'd1);

    // R7 idle levels
    wr(A_CTRL, ctrl_word(1, 1'b1, 1'b1));
    chk("R7 mode 3 idles high", {31'd0, spi_sclk}, 32'd1);
    wr(A_CTRL, ctrl_word(1, 1'b0, 1'b1));
    chk("R7 mode 0 idles low", {31'd0, spi_sclk}, 32'd0);

    // R2 zero total ignored
    wr(A_UP, 32'd0);
    wr(A_FRAME, 32'd0);
    repeat (5) @(negedge clk);
    chk("R2 zero total ignored", {31'd0, spi_cs_n}, 32'd1);
    rd(A_STAT, st);
    chk("R2 still ready after zero total", {31'd0, st[7]}, 32'd1);

    // R2 upper count + R12 abort
    resp[0] = 8'hC3; resp[1] = 8'h5A;
    wr(A_TX, 32'hA1);
    wr(A_TX, 32'hB2);
    wr(A_UP, 32'd1);
    wr(A_FRAME, 32'd0);
    repeat (80) @(negedge clk);
    chk("R2 upper count starts a frame", {31'd0, spi_cs_n}, 32'd0);
    chk("R9 stalled after two FIFO bytes", 32'(rise_cnt), 32'd16);
    wr(A_CTRL, 32'd0);
    @(negedge clk);
    chk("R12 chip select high after abort", {31'd0, spi_cs_n}, 32'd1);
    chk("R12 SCLK idle after abort", {31'd0, spi_sclk}, 32'd0);
    rd(A_STAT, st);
    chk("R12 no done flags after abort", {30'd0, st[1:0]}, 32'd0);
    rd(A_RX, d);
    chk("R3 first byte of aborted frame", d, 32'hC3);
    rd(A_RX, d);
    chk("R3 second byte of aborted frame", d, 32'h5A);
    wr(A_STAT, 32'h7);
    wr(A_UP, 32'd0);

    // directed frames
    run_frame(2, 0, 1, 1'b0, 30, 0, 1'b0, 1'b0);   // R9 transmit stall
    run_frame(8, 2, 1, 1'b1, 0, 150, 1'b0, 1'b0);  // R9 receive back-pressure, R5
    run_frame(3, 0, 2, 1'b0, 0, 0, 1'b1, 1'b0);    // R2 rewrite while busy
    run_frame(4, 4, 3, 1'b1, 0, 0, 1'b0, 1'b0);    // R4 cmd equals total
    run_frame(3, 5, 0, 1'b0, 0, 0, 1'b0, 1'b0);    // R4 cmd above total, rate 0

    // R10 / R11 status and interrupt
    run_frame(1, 1, 1, 1'b0, 0, 0, 1'b0, 1'b1);
    rd(A_STAT, st);
    chk("R10 STATUS after command-only frame", st, 32'h9B);
    wr(A_IEN, 32'h01);
    chk("R11 irq on enabled transmit done", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h01);
    rd(A_STAT, st);
    chk("R10 write-one clears only bit 0", st, 32'h9A);
    chk("R11 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'h02);
    chk("R11 irq on enabled frame done", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h02);
    wr(A_IEN, 32'h00);
    rd(A_STAT, st);
    chk("R10 all latched flags cleared", st, 32'h98);
    chk("R11 irq low with mask clear", {31'd0, irq}, 32'd0);

    // random frames
    for (int k = 0; k < 16; k++) begin
      int t, c, r;
      bit p;
      t = 1 + int'($urandom % 8);
      c = int'($urandom % (t + 2));
      r = int'($urandom % 5);
      p = 1'($urandom % 2);
      run_frame(t, c, r, p, 0, 0, 1'b0, 1'b0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule